// File: doc/BRIEF.md
# DDR Write Strobe Capture

This block is the receive side of a double-data-rate write burst. A fast sampling clock watches the data strobe and the data and mask inputs. After a write command, the block takes one data element on each strobe transition. The first element is taken on the first rising transition, and later elements alternate between falling and rising transitions. The block joins every two elements into one double-width word and presents it to the storage array with a two-bit mask and a single-cycle valid pulse.

While it captures, the block checks that the strobe is quiet on both sides of the burst. The strobe must stay low from the command until its first rising transition, and it must stay low for a short window after the last element. Any violation raises a sticky error, and capture carries on.

The block handles three ways of continuing or ending a burst:
- A write command that arrives during a burst lengthens the burst, and the data continues without a gap.
- A truncation input, raised by a read or precharge that cuts the burst short, forces the mask on every element still to come in that burst.
- Once a burst and its postamble window have ended, strobe activity is ignored.

Top module: `ddr_wr_capture`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears state. After that edge, `pair_valid` and `strobe_err` are 0.
- R2: After a write command, element 0 is the data on the first rising strobe transition, and element k+1 is the data on the next transition of the opposite direction. Each word carries the even element in bits [DW-1:0] and the following odd element in bits [2*DW-1:DW].
- R3: A write burst yields exactly BURST_LEN/2 words. `pair_valid` is high for one cycle per word and is never high in two consecutive cycles.
- R4: `pair_mask[0]` is the mask input taken with the even element of the word, and `pair_mask[1]` is the mask input taken with the odd element (1 = do not write).
- R5: A falling strobe transition between a write command and its first rising transition sets `strobe_err`. The burst is still captured in full.
- R6: A rising strobe transition within POST_LEN sampling cycles after the last element sets `strobe_err` and produces no word.
- R7: A delay from the command to the first rising strobe transition of 3, 4 or 5 sampling cycles (75 %, 100 % and 125 % of a 4-cycle clock period) captures the same words.
- R8: After a burst and its postamble window have ended, with no new command, strobe transitions and data produce no word and do not change `strobe_err`.
- R9: A write command sampled during the data phase adds BURST_LEN elements to the burst, so the words continue with no gap.
- R10: From the element sampled together with `wr_cut` up to the end of the burst, every element has its mask bit forced to 1. Elements before it keep their own mask.
- R11: `strobe_err` stays 1 once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, several times the memory clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_cmd | input | 1 | One-cycle write command pulse |
| wr_cut | input | 1 | One-cycle truncation by a following read or precharge |
| strobe | input | 1 | Write data strobe |
| din | input | DW | Data element |
| din_mask | input | 1 | Mask for the element on the data input |
| pair_valid | output | 1 | One-cycle pulse: a word is ready |
| pair_data | output | 2*DW | {odd element, even element} |
| pair_mask | output | 2 | {odd mask, even mask} |
| strobe_err | output | 1 | Sticky preamble or postamble error |

## Verification
The test sends single bursts with the first strobe rise at the early, nominal and late limits of the command-to-strobe delay. The words must come out the same in every case, which separates capture on strobe transitions from capture on a fixed clock count. The bursts use mask patterns with opposite halves set, which checks that the mask bits and the data halves stay paired. A burst lengthened by a second command, and a burst cut mid-way, check the element count and the forced masking. Strobe activity after a burst must give no word. A strobe left high into the preamble, and a stray rise in the postamble, must set the error flag while the burst around them is still captured.

// File: rtl/dsc_pkg.sv
// Shared types for the DDR write strobe capture block.
package dsc_pkg;

    // Burst phase seen by the tracker
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no burst, strobe ignored
        ST_PRE  = 2'd1,   // command seen, waiting for first rising edge
        ST_DATA = 2'd2,   // capturing elements on every strobe edge
        ST_POST = 2'd3    // last element taken, strobe must stay low
    } cap_state_t;

endpackage

// File: rtl/dsc_strobe_sampler.sv
// Registers strobe, data, mask and command inputs in the sampling clock
// domain and derives rising/falling strobe edge pulses.
// Assumes strobe and data are stable for at least one sampling cycle.
module dsc_strobe_sampler #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_in,
    input  logic          cut_in,
    input  logic          strobe_in,
    input  logic [DW-1:0] data_in,
    input  logic          mask_in,
    output logic          cmd_s,
    output logic          cut_s,
    output logic [DW-1:0] data_s,
    output logic          mask_s,
    output logic          edge_rise,
    output logic          edge_fall
);

    logic strobe_s;
    logic strobe_p;

    // Sample all inputs together so strobe and data stay aligned
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_s    <= 1'b0;
            cut_s    <= 1'b0;
            strobe_s <= 1'b0;
            strobe_p <= 1'b0;
            data_s   <= '0;
            mask_s   <= 1'b0;
        end else begin
            cmd_s    <= cmd_in;
            cut_s    <= cut_in;
            strobe_s <= strobe_in;
            strobe_p <= strobe_s;
            data_s   <= data_in;
            mask_s   <= mask_in;
        end
    end

    // Edge pulses from the last two strobe samples
    assign edge_rise = strobe_s & ~strobe_p;
    assign edge_fall = ~strobe_s & strobe_p;

endmodule

// File: rtl/dsc_burst_tracker.sv
// Tracks a write burst: preamble wait, element counting, extension by
// further commands, truncation masking and the postamble window.
// Raises a sticky error on a falling edge in preamble or a rising edge in
// postamble. Assumes BURST_LEN is even.
module dsc_burst_tracker
    import dsc_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int POST_LEN  = 2,
    parameter int MAX_PEND  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd,
    input  logic       cut,
    input  logic       edge_rise,
    input  logic       edge_fall,
    output logic       take,
    output logic       force_mask,
    output logic       busy,
    output logic       err,
    output cap_state_t state
);

    localparam int CW = $clog2(MAX_PEND + 1);
    localparam int TW = $clog2(POST_LEN + 1);
    localparam logic [CW:0]   BL_W  = (CW + 1)'(BURST_LEN);
    localparam logic [CW:0]   MAX_W = (CW + 1)'(MAX_PEND);
    localparam logic [TW-1:0] T_END = TW'(POST_LEN - 1);

    cap_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [TW-1:0] tmr_q, tmr_d;
    logic          mask_q, mask_d;
    logic          err_q, err_set;
    logic [CW:0]   sum;

    // Next-state, count and error decisions for one sampling cycle
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        tmr_d   = tmr_q;
        mask_d  = mask_q;
        err_set = 1'b0;
        take    = 1'b0;
        sum     = '0;
        case (state_q)
            ST_IDLE: begin
                if (cmd) begin
                    state_d = ST_PRE;
                    cnt_d   = CW'(BURST_LEN);
                    mask_d  = 1'b0;
                end
            end
            ST_PRE, ST_DATA: begin
                if (state_q == ST_PRE) begin
                    take    = edge_rise;
                    err_set = edge_fall;
                end else begin
                    take = edge_rise | edge_fall;
                end
                if (cut) mask_d = 1'b1;
                sum = {1'b0, cnt_q} - {{CW{1'b0}}, take} + (cmd ? BL_W : '0);
                if (sum > MAX_W) sum = MAX_W;
                cnt_d = sum[CW-1:0];
                if (take) state_d = ST_DATA;
                if (sum == '0) begin
                    state_d = ST_POST;
                    tmr_d   = '0;
                end
            end
            default: begin
                err_set = edge_rise & ~cmd;
                if (cmd) begin
                    state_d = ST_DATA;
                    cnt_d   = CW'(BURST_LEN);
                    mask_d  = 1'b0;
                end else if (tmr_q == T_END) begin
                    state_d = ST_IDLE;
                end else begin
                    tmr_d = tmr_q + 1'b1;
                end
            end
        endcase
    end

    // State registers and sticky error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            tmr_q   <= '0;
            mask_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            tmr_q   <= tmr_d;
            mask_q  <= mask_d;
            err_q   <= err_q | err_set;
        end
    end

    // Truncation applies from the element sampled with it onward
    assign force_mask = mask_q | (cut & (state_q == ST_PRE || state_q == ST_DATA));
    assign busy       = (state_q != ST_IDLE);
    assign err        = err_q;
    assign state      = state_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q); // R11
    AST_POST_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POST) |-> (cnt_q == '0)); // R3
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, cnt_q} <= MAX_W); // R9

endmodule

// File: rtl/dsc_pair_packer.sv
// Joins captured elements two at a time into a double-width word with a
// two-bit mask and a one-cycle valid pulse. Even element goes low.
// Assumes the tracker delivers an even number of elements per burst.
module dsc_pair_packer #(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            busy,
    input  logic            take,
    input  logic [DW-1:0]   data,
    input  logic            mask,
    output logic            half,
    output logic            word_valid,
    output logic [2*DW-1:0] word_data,
    output logic [1:0]      word_mask
);

    logic [DW-1:0] lo_data;
    logic          lo_mask;

    // Hold the even element, then emit the pair on the odd one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half       <= 1'b0;
            lo_data    <= '0;
            lo_mask    <= 1'b0;
            word_valid <= 1'b0;
            word_data  <= '0;
            word_mask  <= 2'b00;
        end else begin
            word_valid <= take & half;
            if (!busy) begin
                half <= 1'b0;
            end else if (take && !half) begin
                lo_data <= data;
                lo_mask <= mask;
                half    <= 1'b1;
            end else if (take) begin
                word_data <= {data, lo_data};
                word_mask <= {mask, lo_mask};
                half      <= 1'b0;
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid); // R3

endmodule

// File: rtl/ddr_wr_capture.sv
// Top of the DDR write strobe capture: sampler, burst tracker, pair packer.
// Assumes clk oversamples the strobe so that every strobe level lasts at
// least one sampling cycle.
module ddr_wr_capture
    import dsc_pkg::*;
#(
    parameter int DW        = 8,
    parameter int BURST_LEN = 4,
    parameter int POST_LEN  = 2,
    parameter int MAX_PEND  = 4 * BURST_LEN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_cmd,
    input  logic            wr_cut,
    input  logic            strobe,
    input  logic [DW-1:0]   din,
    input  logic            din_mask,
    output logic            pair_valid,
    output logic [2*DW-1:0] pair_data,
    output logic [1:0]      pair_mask,
    output logic            strobe_err
);

    generate
        if (BURST_LEN % 2 != 0) begin : g_bad_len
            $error("BURST_LEN must be even");
        end
    endgenerate

    logic          cmd_s, cut_s, mask_s, rise, fall;
    logic [DW-1:0] data_s;
    logic          take, force_mask, busy, half;
    cap_state_t    trk_state;

    dsc_strobe_sampler #(.DW(DW)) i_sampler (
        .clk(clk), .rst_n(rst_n),
        .cmd_in(wr_cmd), .cut_in(wr_cut), .strobe_in(strobe),
        .data_in(din), .mask_in(din_mask),
        .cmd_s(cmd_s), .cut_s(cut_s), .data_s(data_s), .mask_s(mask_s),
        .edge_rise(rise), .edge_fall(fall)
    );

    dsc_burst_tracker #(
        .BURST_LEN(BURST_LEN), .POST_LEN(POST_LEN), .MAX_PEND(MAX_PEND)
    ) i_tracker (
        .clk(clk), .rst_n(rst_n),
        .cmd(cmd_s), .cut(cut_s), .edge_rise(rise), .edge_fall(fall),
        .take(take), .force_mask(force_mask), .busy(busy),
        .err(strobe_err), .state(trk_state)
    );

    dsc_pair_packer #(.DW(DW)) i_packer (
        .clk(clk), .rst_n(rst_n),
        .busy(busy), .take(take), .data(data_s), .mask(mask_s | force_mask),
        .half(half), .word_valid(pair_valid),
        .word_data(pair_data), .word_mask(pair_mask)
    );

    AST_WORD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> $past(fall)); // R2
    AST_PAIR_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_state == ST_POST) |-> !half); // R3
    AST_ERR_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_err) |-> $past(rise | fall)); // R5 R6

endmodule

// File: tb/test_ddr_wr_capture.sv
// Scoreboard bench: the burst driver queues expected words, a monitor
// pops and compares them whenever the design presents a word.
module test_ddr_wr_capture;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 8;
    localparam int BL         = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_cmd = 1'b0;
    logic            wr_cut = 1'b0;
    logic            strobe = 1'b0;
    logic [DW-1:0]   din = '0;
    logic            din_mask = 1'b0;
    logic            pair_valid;
    logic [2*DW-1:0] pair_data;
    logic [1:0]      pair_mask;
    logic            strobe_err;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";
    logic [2*DW+1:0] exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    ddr_wr_capture #(.DW(DW), .BURST_LEN(BL), .POST_LEN(2)) i_ddr_wr_capture (
        .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wr_cut(wr_cut),
        .strobe(strobe), .din(din), .din_mask(din_mask),
        .pair_valid(pair_valid), .pair_data(pair_data),
        .pair_mask(pair_mask), .strobe_err(strobe_err)
    );

    // Monitor: compare each produced word with the head of the queue
    always @(negedge clk) begin
        if (rst_n && pair_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL %s unexpected word actual %h/%b expected none",
                         cur_tag, pair_data, pair_mask);
            end else begin
                logic [2*DW+1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({pair_mask, pair_data} !== e) begin
                    errors++;
                    $display("FAIL %s word actual %b/%h expected %b/%h",
                             t, pair_mask, pair_data, e[2*DW+1:2*DW], e[2*DW-1:0]);
                end
            end
        end
    end

    task automatic chk(input logic act, input logic expv, input string tag);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual %b expected %b", tag, act, expv);
        end
    endtask

    task automatic chk_drained(input string tag);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s words missing actual %0d left expected 0", tag, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: command, preamble of dly cycles, nel elements of 2 cycles each
    task automatic burst(input int dly, input int nel, input logic [7:0] base,
                         input logic [15:0] mpat, input int cmd_idx,
                         input int cut_idx, input bit pre_high,
                         input bit post_bad, input string tag);
        for (int p = 0; p < nel / 2; p++) begin
            logic m0, m1;
            m0 = mpat[2*p]   | (cut_idx >= 0 && 2*p     >= cut_idx);
            m1 = mpat[2*p+1] | (cut_idx >= 0 && 2*p + 1 >= cut_idx);
            exp_q.push_back({m1, m0, base + 8'(2*p + 1), base + 8'(2*p)});
            tag_q.push_back(tag);
        end
        @(negedge clk);
        wr_cmd = 1'b1;
        strobe = pre_high;
        for (int c = 1; c < dly; c++) begin
            @(negedge clk);
            wr_cmd = 1'b0;
            strobe = (pre_high && c == 1);
        end
        for (int i = 0; i < nel; i++) begin
            @(negedge clk);
            strobe   = ~i[0];
            din      = base + 8'(i);
            din_mask = mpat[i];
            wr_cmd   = (i == cmd_idx);
            wr_cut   = (i == cut_idx);
            @(negedge clk);
            wr_cmd = 1'b0;
            wr_cut = 1'b0;
        end
        @(negedge clk);
        din_mask = 1'b0;
        if (post_bad) begin
            strobe = 1'b1;
            din    = 8'hEE;
            wait_cyc(2);
            strobe = 1'b0;
        end
    endtask

    initial begin
        // R1: reset state
        wait_cyc(3);
        chk(pair_valid, 1'b0, "R1 valid after reset");
        chk(strobe_err, 1'b0, "R1 error after reset");
        rst_n = 1'b1;
        wait_cyc(2);

        // R2 R7: nominal, early and late first rise
        cur_tag = "R2";
        burst(4, 4, 8'h10, 16'h0, -1, -1, 0, 0, "R2 nominal delay");
        wait_cyc(8);
        chk_drained("R3 nominal burst word count");
        cur_tag = "R7";
        burst(3, 4, 8'h20, 16'b0110, -1, -1, 0, 0, "R7 R4 early delay");
        wait_cyc(8);
        chk_drained("R7 early burst word count");
        burst(5, 4, 8'h30, 16'b1001, -1, -1, 0, 0, "R7 R4 late delay");
        wait_cyc(8);
        chk_drained("R7 late burst word count");
        chk(strobe_err, 1'b0, "R5 no error on clean bursts");

        // R9: second command during data extends the burst
        cur_tag = "R9";
        burst(4, 8, 8'h40, 16'h0, 2, -1, 0, 0, "R9 concatenated burst");
        wait_cyc(8);
        chk_drained("R9 concatenated word count");

        // R10: truncation masks the rest of the burst
        cur_tag = "R10";
        burst(4, 4, 8'h50, 16'h0, -1, 2, 0, 0, "R10 truncated burst");
        wait_cyc(8);
        chk_drained("R10 truncated word count");

        // R8: strobe activity with no command is ignored
        cur_tag = "R8";
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            strobe = ~k[0];
            din    = 8'hA0 + 8'(k);
            wait_cyc(1);
        end
        @(negedge clk);
        strobe = 1'b0;
        wait_cyc(6);
        chk(strobe_err, 1'b0, "R8 idle strobe leaves error clear");
        chk_drained("R8 no stray words");

        // R5: strobe high into the preamble, capture still done
        cur_tag = "R5";
        burst(4, 4, 8'h60, 16'h0, -1, -1, 1, 0, "R5 burst after bad preamble");
        wait_cyc(8);
        chk(strobe_err, 1'b1, "R5 preamble error set");
        chk_drained("R5 word count");
        cur_tag = "R11";
        burst(4, 4, 8'h70, 16'h0, -1, -1, 0, 0, "R11 burst with error held");
        wait_cyc(8);
        chk(strobe_err, 1'b1, "R11 error stays set");

        // R11 R1: reset clears the error
        rst_n = 1'b0;
        wait_cyc(2);
        rst_n = 1'b1;
        wait_cyc(2);
        chk(strobe_err, 1'b0, "R11 error cleared by reset");

        // R6: rising strobe in the postamble window
        cur_tag = "R6";
        burst(4, 4, 8'h80, 16'h0, -1, -1, 0, 1, "R6 burst before bad postamble");
        wait_cyc(8);
        chk(strobe_err, 1'b1, "R6 postamble error set");
        chk_drained("R6 no word from stray rise");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run ends as a failure
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule